// File: doc/BRIEF.md
# Packed Multiply and Absolute-Difference Unit

This block is a 64-bit SIMD arithmetic stage that treats its two operands as four 16-bit halfword lanes or eight 8-bit byte lanes. Depending on a 4-bit operation code, it can produce four kinds of result. The first is a lane-wise 16x16 multiply that returns either the low or the high half of each product. The second is a pairwise multiply-add that folds neighbouring products into two 32-bit words. The third is a full four-lane multiply-sum that yields one 64-bit value. The fourth is a sum of absolute differences over byte or halfword lanes. Signed and unsigned variants are selected by the operation code.

All arithmetic is combinational. The result lands in an output register that loads only on cycles where the input valid is high, and a matching valid bit follows one cycle later. An operation code outside the defined set raises a decode-error bit and forces the result to zero. The unit does not accumulate into an external register, does not saturate and does not produce flags.

Top module: `pmsad_unit`

## Requirements
- R1: Opcodes 0 (signed) and 1 (unsigned) put bits 15:0 of the product of halfword lane i of A and lane i of B into result bits 16i+15:16i, for i = 0..3.
- R2: Opcodes 2 (signed) and 3 (unsigned) put bits 31:16 of each lane product into that lane's 16 result bits. The signed form sign-extends both lane operands and the unsigned form zero-extends them.
- R3: Opcode 4 sign-extends all lanes, adds the products of lanes 0 and 1 into result bits 31:0, and adds the products of lanes 2 and 3 into result bits 63:32. Each word keeps the low 32 bits of its sum.
- R4: Opcode 5 performs the same pairwise form as R3 with zero-extended lanes.
- R5: Opcode 7 returns the unsigned sum of all four zero-extended lane products as one 64-bit value.
- R6: Opcode 6 returns the sum of all four lane products with A lanes taken as unsigned and B lanes taken as signed, sign-extended to 64 bits.
- R7: Opcode 8 returns the sum over all eight byte lanes of |A byte - B byte| (unsigned), zero-extended, so the result never exceeds 2040.
- R8: Opcode 9 returns the sum over the four halfword lanes of |A lane - B lane| (unsigned), zero-extended, so the result never exceeds 262140.
- R9: Opcodes 10 to 15 set decodeErr in the cycle their result is presented and force the result to zero. Defined opcodes clear decodeErr.
- R10: result and decodeErr load only on a clock edge with validIn high and otherwise hold. resValid equals validIn delayed by one cycle.
- R11: While rstN is low, result is zero and resValid and decodeErr are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| validIn | input | 1 | Operands and opcode are valid this cycle |
| opcode | input | 4 | Operation select (0-9 defined) |
| opA | input | 64 | Operand A |
| opB | input | 64 | Operand B |
| result | output | 64 | Registered result |
| resValid | output | 1 | Result loaded on the previous edge |
| decodeErr | output | 1 | Registered undefined-opcode flag |

## Verification
A wrong strobe from the decoder, such as a missing sign-extension or the wrong result select, shows up as a wrong result in the cycle right after the offending operation. It is caught by comparing every operation against an independent lane model, with sign-heavy and all-ones patterns that make signed and unsigned forms disagree. An output register that loads when it should not is caught at the first idle cycle: the bench drives changed operands with validIn low and watches that result, resValid and decodeErr do not move. Decode errors are checked for both the zeroed result and the flag.

// File: rtl/pmsad_pkg.sv
package pmsad_pkg;

  typedef enum logic [2:0] {
    RS_LANE_LO = 3'd0,
    RS_LANE_HI = 3'd1,
    RS_PAIR    = 3'd2,
    RS_SUM     = 3'd3,
    RS_SAD_B   = 3'd4,
    RS_SAD_H   = 3'd5,
    RS_ZERO    = 3'd6
  } resSel_e;

  typedef struct packed {
    logic    aSigned;
    logic    bSigned;
    resSel_e resSel;
    logic    badOp;
  } ctrlStrobe_t;

  localparam logic [3:0] OPC_MUL_LO_S = 4'd0;
  localparam logic [3:0] OPC_MUL_LO_U = 4'd1;
  localparam logic [3:0] OPC_MUL_HI_S = 4'd2;
  localparam logic [3:0] OPC_MUL_HI_U = 4'd3;
  localparam logic [3:0] OPC_PAIR_S   = 4'd4;
  localparam logic [3:0] OPC_PAIR_U   = 4'd5;
  localparam logic [3:0] OPC_SUM_S    = 4'd6;
  localparam logic [3:0] OPC_SUM_U    = 4'd7;
  localparam logic [3:0] OPC_SAD_B    = 4'd8;
  localparam logic [3:0] OPC_SAD_H    = 4'd9;

endpackage

// File: rtl/pmsad_ctrl.sv
module pmsad_ctrl
  import pmsad_pkg::*;
(
  input  logic [3:0]  opcode,
  output ctrlStrobe_t strobe
);

  always_comb begin
    strobe.aSigned = 1'b0;
    strobe.bSigned = 1'b0;
    strobe.resSel  = RS_ZERO;
    strobe.badOp   = 1'b0;
    case (opcode)
      OPC_MUL_LO_S: begin strobe.resSel = RS_LANE_LO; strobe.aSigned = 1'b1; strobe.bSigned = 1'b1; end
      OPC_MUL_LO_U: strobe.resSel = RS_LANE_LO;
      OPC_MUL_HI_S: begin strobe.resSel = RS_LANE_HI; strobe.aSigned = 1'b1; strobe.bSigned = 1'b1; end
      OPC_MUL_HI_U: strobe.resSel = RS_LANE_HI;
      OPC_PAIR_S:   begin strobe.resSel = RS_PAIR; strobe.aSigned = 1'b1; strobe.bSigned = 1'b1; end
      OPC_PAIR_U:   strobe.resSel = RS_PAIR;
      OPC_SUM_S:    begin strobe.resSel = RS_SUM; strobe.bSigned = 1'b1; end
      OPC_SUM_U:    strobe.resSel = RS_SUM;
      OPC_SAD_B:    strobe.resSel = RS_SAD_B;
      OPC_SAD_H:    strobe.resSel = RS_SAD_H;
      default:      strobe.badOp  = 1'b1;
    endcase
  end

endmodule

// File: rtl/pmsad_dp.sv
module pmsad_dp
  import pmsad_pkg::*;
#(
  parameter int DATA_W = 64,
  parameter int HALF_W = 16,
  parameter int BYTE_W = 8
) (
  input  ctrlStrobe_t       strobe,
  input  logic [DATA_W-1:0] opA,
  input  logic [DATA_W-1:0] opB,
  output logic [DATA_W-1:0] dpResult
);

  localparam int NH      = DATA_W / HALF_W;
  localparam int NB      = DATA_W / BYTE_W;
  localparam int NP      = NH / 2;
  localparam int PW      = 2 * HALF_W + 2;
  localparam int PAIR_W  = 2 * HALF_W;
  localparam int SADB_W  = BYTE_W + $clog2(NB);
  localparam int SADH_W  = HALF_W + $clog2(NH);

  logic signed [PW-1:0] prod [NH];
  logic [DATA_W-1:0]    laneLo;
  logic [DATA_W-1:0]    laneHi;
  logic [DATA_W-1:0]    pairVec;
  logic [DATA_W-1:0]    sumAll;
  logic [BYTE_W-1:0]    diffB [NB];
  logic [HALF_W-1:0]    diffH [NH];
  logic [SADB_W-1:0]    sadB;
  logic [SADH_W-1:0]    sadH;

  // One 17x17 signed multiplier per halfword lane; the extension bit
  // carries the signedness chosen by the decoder.
  for (genvar h = 0; h < NH; h++) begin : g_lane
    logic [HALF_W-1:0]      aLane;
    logic [HALF_W-1:0]      bLane;
    logic signed [HALF_W:0] aExt;
    logic signed [HALF_W:0] bExt;
    assign aLane = opA[h*HALF_W +: HALF_W];
    assign bLane = opB[h*HALF_W +: HALF_W];
    assign aExt  = {strobe.aSigned & aLane[HALF_W-1], aLane};
    assign bExt  = {strobe.bSigned & bLane[HALF_W-1], bLane};
    assign prod[h] = aExt * bExt;
    assign laneLo[h*HALF_W +: HALF_W] = prod[h][HALF_W-1:0];
    assign laneHi[h*HALF_W +: HALF_W] = prod[h][2*HALF_W-1:HALF_W];
    assign diffH[h] = (aLane > bLane) ? (aLane - bLane) : (bLane - aLane);
  end

  for (genvar p = 0; p < NP; p++) begin : g_pair
    assign pairVec[p*PAIR_W +: PAIR_W] =
      prod[2*p][PAIR_W-1:0] + prod[2*p+1][PAIR_W-1:0];
  end

  for (genvar b = 0; b < NB; b++) begin : g_byte
    logic [BYTE_W-1:0] aByte;
    logic [BYTE_W-1:0] bByte;
    assign aByte = opA[b*BYTE_W +: BYTE_W];
    assign bByte = opB[b*BYTE_W +: BYTE_W];
    assign diffB[b] = (aByte > bByte) ? (aByte - bByte) : (bByte - aByte);
  end

  always_comb begin
    sumAll = '0;
    for (int h = 0; h < NH; h++) begin
      sumAll = sumAll + {{(DATA_W-PW){prod[h][PW-1]}}, prod[h]};
    end
  end

  always_comb begin
    sadB = '0;
    for (int b = 0; b < NB; b++) begin
      sadB = sadB + SADB_W'(diffB[b]);
    end
  end

  always_comb begin
    sadH = '0;
    for (int h = 0; h < NH; h++) begin
      sadH = sadH + SADH_W'(diffH[h]);
    end
  end

  always_comb begin
    case (strobe.resSel)
      RS_LANE_LO: dpResult = laneLo;
      RS_LANE_HI: dpResult = laneHi;
      RS_PAIR:    dpResult = pairVec;
      RS_SUM:     dpResult = sumAll;
      RS_SAD_B:   dpResult = DATA_W'(sadB);
      RS_SAD_H:   dpResult = DATA_W'(sadH);
      default:    dpResult = '0;
    endcase
  end

endmodule

// File: rtl/pmsad_unit.sv
module pmsad_unit
  import pmsad_pkg::*;
#(
  parameter int DATA_W = 64,
  parameter int HALF_W = 16,
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              validIn,
  input  logic [3:0]        opcode,
  input  logic [DATA_W-1:0] opA,
  input  logic [DATA_W-1:0] opB,
  output logic [DATA_W-1:0] result,
  output logic              resValid,
  output logic              decodeErr
);

  ctrlStrobe_t       strobe;
  logic [DATA_W-1:0] dpResult;

  pmsad_ctrl u_ctrl (
    .opcode (opcode),
    .strobe (strobe)
  );

  pmsad_dp #(
    .DATA_W (DATA_W),
    .HALF_W (HALF_W),
    .BYTE_W (BYTE_W)
  ) u_dp (
    .strobe   (strobe),
    .opA      (opA),
    .opB      (opB),
    .dpResult (dpResult)
  );

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      result    <= '0;
      resValid  <= 1'b0;
      decodeErr <= 1'b0;
    end else begin
      resValid <= validIn;
      if (validIn) begin
        result    <= dpResult;
        decodeErr <= strobe.badOp;
      end
    end
  end

endmodule

// File: rtl/pmsad_unit_chk.sv
module pmsad_unit_chk #(
  parameter int DATA_W = 64
) (
  input logic              clk,
  input logic              rstN,
  input logic              validIn,
  input logic [3:0]        opcode,
  input logic [DATA_W-1:0] result,
  input logic              resValid,
  input logic              decodeErr
);

  p_valid_follow_r10: assert property (@(posedge clk) disable iff (!rstN)
    validIn |=> resValid);

  p_valid_drop_r10: assert property (@(posedge clk) disable iff (!rstN)
    !validIn |=> !resValid);

  p_hold_when_idle_r10: assert property (@(posedge clk) disable iff (!rstN)
    !validIn |=> ($stable(result) && $stable(decodeErr)));

  p_bad_op_flag_r9: assert property (@(posedge clk) disable iff (!rstN)
    (validIn && opcode > 4'd9) |=> (decodeErr && result == '0));

  p_good_op_clear_r9: assert property (@(posedge clk) disable iff (!rstN)
    (validIn && opcode <= 4'd9) |=> !decodeErr);

  p_sad_byte_range_r7: assert property (@(posedge clk) disable iff (!rstN)
    (validIn && opcode == 4'd8) |=> (result <= DATA_W'(2040)));

  p_sad_half_range_r8: assert property (@(posedge clk) disable iff (!rstN)
    (validIn && opcode == 4'd9) |=> (result <= DATA_W'(262140)));

endmodule

bind pmsad_unit pmsad_unit_chk #(.DATA_W(DATA_W)) u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .validIn   (validIn),
  .opcode    (opcode),
  .result    (result),
  .resValid  (resValid),
  .decodeErr (decodeErr)
);

// File: tb/pmsad_unit_test.sv
module pmsad_unit_test;

  typedef struct {
    logic [63:0] res;
    logic        err;
    string       tag;
  } expItem_t;

  logic        clk = 1'b0;
  logic        rstN;
  logic        validIn;
  logic [3:0]  opcode;
  logic [63:0] opA;
  logic [63:0] opB;
  logic [63:0] result;
  logic        resValid;
  logic        decodeErr;

  int checks = 0;
  int errors = 0;
  expItem_t expQ[$];
  logic [63:0] rng = 64'h1234_5678_9ABC_DEF1;

  always #10 clk = ~clk;

  pmsad_unit uut (
    .clk(clk), .rstN(rstN), .validIn(validIn), .opcode(opcode),
    .opA(opA), .opB(opB), .result(result), .resValid(resValid),
    .decodeErr(decodeErr)
  );

  function automatic string tagOf(input logic [3:0] op);
    case (op)
      4'd0, 4'd1: return "R1";
      4'd2, 4'd3: return "R2";
      4'd4:       return "R3";
      4'd5:       return "R4";
      4'd6:       return "R6";
      4'd7:       return "R5";
      4'd8:       return "R7";
      4'd9:       return "R8";
      default:    return "R9";
    endcase
  endfunction

  function automatic longint laneVal(input logic [15:0] v, input bit sgn);
    if (sgn) return longint'(shortint'(v));
    return longint'({48'b0, v});
  endfunction

  function automatic expItem_t model(input logic [3:0] op,
                                     input logic [63:0] a, input logic [63:0] b);
    expItem_t e;
    longint pr [4];
    longint acc;
    logic [63:0] t;
    bit sa, sb;
    e.res = '0;
    e.err = 1'b0;
    e.tag = tagOf(op);
    sa = (op == 4'd0 || op == 4'd2 || op == 4'd4);
    sb = sa || (op == 4'd6);
    for (int i = 0; i < 4; i++)
      pr[i] = laneVal(a[i*16 +: 16], sa) * laneVal(b[i*16 +: 16], sb);
    case (op)
      4'd0, 4'd1: for (int i = 0; i < 4; i++) begin
                    t = pr[i]; e.res[i*16 +: 16] = t[15:0];
                  end
      4'd2, 4'd3: for (int i = 0; i < 4; i++) begin
                    t = pr[i]; e.res[i*16 +: 16] = t[31:16];
                  end
      4'd4, 4'd5: for (int w = 0; w < 2; w++) begin
                    t = pr[2*w] + pr[2*w+1]; e.res[w*32 +: 32] = t[31:0];
                  end
      4'd6, 4'd7: begin
                    acc = pr[0] + pr[1] + pr[2] + pr[3];
                    e.res = acc;
                  end
      4'd8: begin
              acc = 0;
              for (int i = 0; i < 8; i++) begin
                if (a[i*8 +: 8] > b[i*8 +: 8]) acc += longint'(a[i*8 +: 8] - b[i*8 +: 8]);
                else acc += longint'(b[i*8 +: 8] - a[i*8 +: 8]);
              end
              e.res = acc;
            end
      4'd9: begin
              acc = 0;
              for (int i = 0; i < 4; i++) begin
                if (a[i*16 +: 16] > b[i*16 +: 16]) acc += longint'(a[i*16 +: 16] - b[i*16 +: 16]);
                else acc += longint'(b[i*16 +: 16] - a[i*16 +: 16]);
              end
              e.res = acc;
            end
      default: e.err = 1'b1;
    endcase
    return e;
  endfunction

  function automatic logic [63:0] nextRand(input logic [63:0] s);
    logic [63:0] x;
    x = s;
    x = x ^ (x << 13);
    x = x ^ (x >> 7);
    x = x ^ (x << 17);
    return x;
  endfunction

  task automatic drive(input logic [3:0] op, input logic [63:0] a, input logic [63:0] b);
    @(negedge clk);
    opcode  = op;
    opA     = a;
    opB     = b;
    validIn = 1'b1;
    expQ.push_back(model(op, a, b));
  endtask

  task automatic idleCheck(input int n);
    logic [63:0] held;
    logic        heldErr;
    @(negedge clk);
    validIn = 1'b0;
    @(negedge clk);
    held    = result;
    heldErr = decodeErr;
    for (int i = 0; i < n; i++) begin
      opcode = 4'(i + 3);
      opA    = ~opA ^ 64'(i);
      opB    = opB + 64'h0101_0101_0101_0101;
      @(negedge clk);
      checks++;
      if (result !== held || resValid !== 1'b0 || decodeErr !== heldErr) begin
        errors++;
        $display("FAIL R10 idle hold: result %h valid %b err %b expected %h 0 %b",
                 result, resValid, decodeErr, held, heldErr);
      end
    end
  endtask

  // Monitor: pop one expected item for every presented result.
  always @(negedge clk) begin
    if (rstN === 1'b1 && resValid === 1'b1) begin
      expItem_t e;
      checks++;
      if (expQ.size() == 0) begin
        errors++;
        $display("FAIL R10 unexpected result %h valid with empty scoreboard", result);
      end else begin
        e = expQ.pop_front();
        if (result !== e.res || decodeErr !== e.err) begin
          errors++;
          $display("FAIL %s result %h err %b expected %h err %b",
                   e.tag, result, decodeErr, e.res, e.err);
        end
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog expired, actual hung expected finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    rstN    = 1'b0;
    validIn = 1'b0;
    opcode  = 4'd0;
    opA     = '1;
    opB     = '1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    checks++;
    if (result !== '0 || resValid !== 1'b0 || decodeErr !== 1'b0) begin
      errors++;
      $display("FAIL R11 reset state: result %h valid %b err %b expected 0 0 0",
               result, resValid, decodeErr);
    end
    rstN = 1'b1;

    // R1/R2 sign-heavy and boundary lanes
    drive(4'd0, 64'hFFFF_8000_0003_7FFF, 64'h0002_8000_FFFF_7FFF);
    drive(4'd1, 64'hFFFF_8000_0003_7FFF, 64'h0002_8000_FFFF_7FFF);
    drive(4'd2, 64'hFFFF_8000_0003_7FFF, 64'h0002_8000_FFFF_7FFF);
    drive(4'd3, 64'hFFFF_8000_0003_7FFF, 64'h0002_8000_FFFF_7FFF);
    drive(4'd3, 64'hFFFF_FFFF_FFFF_FFFF, 64'hFFFF_FFFF_FFFF_FFFF);
    // R3/R4 pairwise, wrap of 32-bit word
    drive(4'd4, 64'h8000_8000_FFFF_0001, 64'h8000_8000_FFFF_FFFF);
    drive(4'd5, 64'hFFFF_FFFF_FFFF_FFFF, 64'hFFFF_FFFF_FFFF_FFFF);
    drive(4'd4, 64'h1234_5678_9ABC_DEF0, 64'h0FED_CBA9_8765_4321);
    // R5/R6 four-lane sums
    drive(4'd7, 64'hFFFF_FFFF_FFFF_FFFF, 64'hFFFF_FFFF_FFFF_FFFF);
    drive(4'd6, 64'hFFFF_FFFF_FFFF_FFFF, 64'h8000_8000_8000_8000);
    drive(4'd6, 64'h0001_0002_0003_0004, 64'hFFFF_0001_FFFF_0001);
    // R7/R8 SAD including maximum values
    drive(4'd8, 64'hFFFF_FFFF_FFFF_FFFF, 64'h0000_0000_0000_0000);
    drive(4'd8, 64'h0010_FF00_8001_7F80, 64'h1000_00FF_0180_807F);
    drive(4'd9, 64'h0000_0000_0000_0000, 64'hFFFF_FFFF_FFFF_FFFF);
    drive(4'd9, 64'h8000_0001_1234_FFFE, 64'h7FFF_0002_4321_FFFE);
    // R9 undefined opcodes
    drive(4'd10, 64'h1111_2222_3333_4444, 64'h5555_6666_7777_8888);
    drive(4'd15, 64'hFFFF_FFFF_FFFF_FFFF, 64'h1);
    drive(4'd8,  64'h0000_0000_0000_0005, 64'h0000_0000_0000_0002);
    idleCheck(3);

    // Pseudo-random traffic with gaps
    for (int k = 0; k < 60; k++) begin
      logic [63:0] a;
      logic [63:0] b;
      rng = nextRand(rng); a = rng;
      rng = nextRand(rng); b = rng;
      drive(4'(k % 11), a, b);
      if (k % 7 == 6) begin
        @(negedge clk);
        validIn = 1'b0;
      end
    end
    idleCheck(2);

    while (expQ.size() != 0) @(negedge clk);
    repeat (2) @(negedge clk);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule